// File: doc/BRIEF.md
# Multiple-Register Load/Store Sequencer

This block carries out one block transfer instruction: it moves a set of registers to or from consecutive memory words. A single-cycle `start` presents a 32-bit opcode together with five control bits (pre-index, up, user bank, writeback and load). Opcode bits 15..0 form the register list, one bit per register. Bits 19..16 name the base register. The sequencer reads the base address from the register file in the start cycle. It then walks the list one register at a time and issues one 32-bit memory access per selected register over a valid/ready handshake.

For loads, each word goes into the register file, or into the user-mode bank when that is requested. For stores, the word comes from one of those two sources. When the access pattern allows it, the final address is written back to the base register. When r15 is loaded under the user-bank bit, the sequencer also emits a single-cycle request to copy the saved status register into the current one. Bank switching, exceptions and decode stay outside the block.

Top module: `multireg_xfer`

## Requirements
- R1: With the up bit at 1, registers are transferred in ascending index order starting from r0. With it at 0, they are transferred in descending order starting from r15.
- R2: Successive accesses step the address by +4 (up) or -4 (down). With pre-index at 1, the first access uses base±4. With it at 0, the first access uses the base itself.
- R3: Each selected register gets exactly one access. `mem_addr`, `mem_we` and `mem_wdata` hold steady while `mem_valid` is high and `mem_ready` is low. Read data is taken in the cycle where both are high.
- R4: With writeback at 1, the base register receives base ± 4·(number of registers). With writeback at 0, the base register is left alone.
- R5: On a load whose base register is in the list, no writeback takes place, and the base register keeps the value that was loaded into it.
- R6: A store of r15 writes the r15 source value plus 8.
- R7: A load of r15 writes the loaded word with bits 1..0 forced to 0.
- R8: A load with the user-bank bit at 1 and bit 15 of the list at 0 writes every loaded word to the user bank (`usr_wr_en`). The normal register file is not touched.
- R9: A load with the user-bank bit at 1 and bit 15 at 1 writes to the normal register file. `status_restore` pulses exactly once, in the cycle in which r15 is written.
- R10: A store with the user-bank bit at 1 takes every value from `usr_rd_data`, whether or not r15 is in the list.
- R11: An empty list (bits 15..0 all zero) makes no memory access. A writeback then rewrites the base register with its own unchanged value.
- R12: `done` is high for exactly one cycle, after the last access and in the same cycle as the writeback. A `start` received while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| opcode | input | 32 | Bits 15..0 register list, bits 19..16 base register |
| pre_index | input | 1 | Step the address before each access |
| up_dir | input | 1 | 1: ascending/+4, 0: descending/-4 |
| user_bank | input | 1 | User-bank transfer or status restore select |
| write_back | input | 1 | Write the final address to the base register |
| load | input | 1 | 1: memory to registers, 0: registers to memory |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_idx | output | 4 | Register read index (base in idle, current register after) |
| rf_rd_data | input | 32 | Register file read data for `rd_idx` |
| usr_rd_data | input | 32 | User-bank read data for `rd_idx` |
| rf_wr_en | output | 1 | Register file write enable |
| usr_wr_en | output | 1 | User-bank write enable |
| wr_idx | output | 4 | Write index for either bank |
| wr_data | output | 32 | Write data for either bank |
| status_restore | output | 1 | Copy saved status into current status |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts or completes the access |
| mem_rdata | input | 32 | Load data, valid when `mem_ready` is high |

## Verification
The bench goes after the orderings first. A sequencer that ignored the direction bit would put r1 and r0 in swapped memory words on a descending store. One that got pre-index wrong would start one word off and end with a writeback value off by four. Loads that include their own base register are checked for a wrongly clobbered loaded value. The empty list is checked for phantom bus cycles, and r15 for a missing +8 offset or unmasked low bits. The two meanings of the user-bank bit are checked separately, because swapping them would land loads in the wrong bank or drop the status-restore pulse. A second `start` is issued in the middle of a slow-memory run; a design that accepted it would add or lose accesses.

// File: rtl/multireg_pkg.sv
package multireg_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_REG = 16;
    localparam int IDX_W   = $clog2(NUM_REG);

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_XFER = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic pre;
        logic up;
        logic usr;
        logic wb;
        logic ld;
    } xfer_ctl_t;

    function automatic logic [DATA_W-1:0] step_addr(input logic [DATA_W-1:0] a,
                                                    input logic up);
        return up ? a + DATA_W'(DATA_W / 8) : a - DATA_W'(DATA_W / 8);
    endfunction

endpackage

// File: rtl/multireg_pick.sv
module multireg_pick #(
    parameter int NREG = multireg_pkg::NUM_REG,
    localparam int IW  = $clog2(NREG)
) (
    input  logic [NREG-1:0] pending,
    input  logic            up,
    output logic [IW-1:0]   idx,
    output logic            any,
    output logic            last
);
    always_comb begin
        idx = '0;
        if (up) begin
            for (int i = NREG - 1; i >= 0; i--)
                if (pending[i]) idx = IW'(i);
        end else begin
            for (int i = 0; i < NREG; i++)
                if (pending[i]) idx = IW'(i);
        end
    end

    assign any  = |pending;
    assign last = ($countones(pending) == 1);
endmodule

// File: rtl/multireg_addr.sv
module multireg_addr #(
    parameter int AW = multireg_pkg::DATA_W
) (
    input  logic [AW-1:0] cur,
    input  logic          pre,
    input  logic          up,
    output logic [AW-1:0] acc_addr,
    output logic [AW-1:0] nxt_addr
);
    assign nxt_addr = multireg_pkg::step_addr(cur, up);
    assign acc_addr = pre ? nxt_addr : cur;
endmodule

// File: rtl/multireg_xfer.sv
module multireg_xfer
    import multireg_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int NREG = NUM_REG,
    parameter int OPW  = 32,
    localparam int IW  = $clog2(NREG),
    localparam int PCI = NREG - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [OPW-1:0] opcode,
    input  logic          pre_index,
    input  logic          up_dir,
    input  logic          user_bank,
    input  logic          write_back,
    input  logic          load,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] rd_idx,
    input  logic [DW-1:0] rf_rd_data,
    input  logic [DW-1:0] usr_rd_data,
    output logic          rf_wr_en,
    output logic          usr_wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] wr_data,
    output logic          status_restore,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata
);
    localparam logic [DW-1:0] PC_OFS   = DW'(8);
    localparam logic [DW-1:0] ALN_MASK = {{(DW-2){1'b1}}, 2'b00};

    seq_state_e      state_q;
    xfer_ctl_t       ctl_q;
    logic [NREG-1:0] pend_q;
    logic [IW-1:0]   base_q;
    logic            base_in_q;
    logic            pc_in_q;
    logic [DW-1:0]   addr_q;

    logic [NREG-1:0] op_list;
    logic [IW-1:0]   op_base;
    logic [IW-1:0]   cur_idx;
    logic            pend_any, pend_last;
    logic [DW-1:0]   acc_addr, nxt_addr;
    logic            hs, hs_load, to_user, fin_wb, cur_is_pc;
    logic [DW-1:0]   src_val, ld_val;

    assign op_list = opcode[NREG-1:0];
    assign op_base = opcode[NREG +: IW];

    multireg_pick #(.NREG(NREG)) u_pick (
        .pending (pend_q),
        .up      (ctl_q.up),
        .idx     (cur_idx),
        .any     (pend_any),
        .last    (pend_last)
    );

    multireg_addr #(.AW(DW)) u_addr (
        .cur      (addr_q),
        .pre      (ctl_q.pre),
        .up       (ctl_q.up),
        .acc_addr (acc_addr),
        .nxt_addr (nxt_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            ctl_q     <= '0;
            pend_q    <= '0;
            base_q    <= '0;
            base_in_q <= 1'b0;
            pc_in_q   <= 1'b0;
            addr_q    <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (start) begin
                    ctl_q     <= '{pre: pre_index, up: up_dir, usr: user_bank,
                                   wb: write_back, ld: load};
                    pend_q    <= op_list;
                    base_q    <= op_base;
                    base_in_q <= op_list[op_base];
                    pc_in_q   <= op_list[PCI];
                    addr_q    <= rf_rd_data;
                    state_q   <= (|op_list) ? SEQ_XFER : SEQ_FIN;
                end
                SEQ_XFER: if (hs) begin
                    addr_q          <= nxt_addr;
                    pend_q[cur_idx] <= 1'b0;
                    if (pend_last) state_q <= SEQ_FIN;
                end
                SEQ_FIN:  state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Bus side
    assign mem_valid = (state_q == SEQ_XFER) && pend_any;
    assign hs        = mem_valid && mem_ready;
    assign mem_we    = !ctl_q.ld;
    assign mem_addr  = acc_addr;
    assign cur_is_pc = (cur_idx == IW'(PCI));
    assign src_val   = ctl_q.usr ? usr_rd_data : rf_rd_data;
    assign mem_wdata = cur_is_pc ? src_val + PC_OFS : src_val;

    // Register side
    assign rd_idx  = (state_q == SEQ_IDLE) ? op_base : cur_idx;
    assign hs_load = hs && ctl_q.ld;
    assign to_user = ctl_q.usr && !pc_in_q;
    assign ld_val  = cur_is_pc ? (mem_rdata & ALN_MASK) : mem_rdata;
    assign fin_wb  = (state_q == SEQ_FIN) && ctl_q.wb && !(ctl_q.ld && base_in_q);

    assign usr_wr_en      = hs_load && to_user;
    assign rf_wr_en       = (hs_load && !to_user) || fin_wb;
    assign wr_idx         = (state_q == SEQ_FIN) ? base_q : cur_idx;
    assign wr_data        = (state_q == SEQ_FIN) ? addr_q : ld_val;
    assign status_restore = hs_load && ctl_q.usr && pc_in_q && cur_is_pc;

    assign busy = (state_q != SEQ_IDLE);
    assign done = (state_q == SEQ_FIN);
endmodule

// File: rtl/multireg_xfer_chk.sv
module multireg_xfer_chk #(
    parameter int DW = 32,
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          rf_wr_en,
    input logic          usr_wr_en,
    input logic [IW-1:0] wr_idx,
    input logic [DW-1:0] wr_data,
    input logic          status_restore,
    input logic          mem_valid,
    input logic          mem_we,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ready
);
    localparam logic [DW-1:0] STEP_P = DW'(DW / 8);
    localparam logic [DW-1:0] STEP_N = '0 - DW'(DW / 8);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_we) && $stable(mem_wdata));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready) ##1 mem_valid |->
            (mem_addr - $past(mem_addr) == STEP_P) || (mem_addr - $past(mem_addr) == STEP_N));

    assert_pc_align_R7: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_ready && !mem_we && (rf_wr_en || usr_wr_en)
            && (wr_idx == IW'(2**IW - 1)) |-> (wr_data[1:0] == 2'b00));

    assert_restore_R9: assert property (@(posedge clk) disable iff (rst)
        status_restore |-> rf_wr_en && !usr_wr_en && (wr_idx == IW'(2**IW - 1)));

    assert_one_bank_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_wr_en, usr_wr_en}));

    assert_store_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_we |-> !rf_wr_en && !usr_wr_en);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_bus_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> busy && !mem_valid);
endmodule

bind multireg_xfer multireg_xfer_chk #(.DW(DW), .IW(IW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .busy           (busy),
    .done           (done),
    .rf_wr_en       (rf_wr_en),
    .usr_wr_en      (usr_wr_en),
    .wr_idx         (wr_idx),
    .wr_data        (wr_data),
    .status_restore (status_restore),
    .mem_valid      (mem_valid),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_ready      (mem_ready)
);

// File: tb/multireg_xfer_tb.sv
`timescale 1ns/1ps
module multireg_xfer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] opcode = '0;
    logic        pre_index = 0, up_dir = 0, user_bank = 0, write_back = 0, load = 0;
    logic        busy, done;
    logic [3:0]  rd_idx, wr_idx;
    logic [31:0] rf_rd_data, usr_rd_data, wr_data;
    logic        rf_wr_en, usr_wr_en, status_restore;
    logic        mem_valid, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    multireg_xfer u_dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .pre_index(pre_index), .up_dir(up_dir), .user_bank(user_bank),
        .write_back(write_back), .load(load), .busy(busy), .done(done),
        .rd_idx(rd_idx), .rf_rd_data(rf_rd_data), .usr_rd_data(usr_rd_data),
        .rf_wr_en(rf_wr_en), .usr_wr_en(usr_wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .status_restore(status_restore),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Bench models of register banks and memory
    logic [31:0] rf  [16];
    logic [31:0] usr [16];
    logic [31:0] mem [256];
    int          lat = 0;
    int          wcnt = 0;
    int          log_n = 0, restore_n = 0, done_n = 0;
    logic [31:0] first_addr = '0;

    assign rf_rd_data  = rf[rd_idx];
    assign usr_rd_data = usr[rd_idx];
    assign mem_ready   = mem_valid && (wcnt >= lat);
    assign mem_rdata   = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (mem_valid && !mem_ready) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (rf_wr_en)  rf[wr_idx]  <= wr_data;
        if (usr_wr_en) usr[wr_idx] <= wr_data;
        if (mem_valid && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (start && !busy) begin
            log_n <= 0; restore_n <= 0; done_n <= 0;
        end else begin
            if (mem_valid && mem_ready) begin
                if (log_n == 0) first_addr <= mem_addr;
                log_n <= log_n + 1;
            end
            if (status_restore) restore_n <= restore_n + 1;
            if (done) done_n <= done_n + 1;
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic init_state();
        for (int i = 0; i < 16; i++) begin
            rf[i]  = 32'hA000_0000 + i;
            usr[i] = 32'hB000_0000 + i;
        end
        for (int i = 0; i < 256; i++) mem[i] = 32'hC000_0000 + i;
        rf[13] = 32'h100;
    endtask

    task automatic launch(input logic [4:0] c, input logic [31:0] op);
        @(negedge clk);
        {pre_index, up_dir, user_bank, write_back, load} = c;
        opcode = op;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    task automatic finish_wait();
        int k;
        k = 0;
        while (!done && k < 500) begin
            @(negedge clk);
            k++;
        end
        check(done, "R12 done reached", {31'b0, done}, 32'h1);
        @(negedge clk);
        check(!done && done_n == 1, "R12 single done pulse", done_n, 32'h1);
    endtask

    task automatic run(input logic [4:0] c, input logic [31:0] op);
        launch(c, op);
        finish_wait();
    endtask

    // ctl order: {pre, up, usr, wb, ld}
    typedef struct packed {
        logic [4:0]  ctl;
        logic [15:0] list;
        logic [3:0]  base;
        logic [31:0] exp_first;
        logic [7:0]  exp_n;
        logic [31:0] exp_base;
        logic        chk_reg;
        logic [7:0]  chk_idx;
        logic [31:0] chk_val;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{5'b01010, 16'h000F, 4'd13, 32'h100, 8'd4, 32'h110, 1'b0, 8'h40, 32'hA000_0000}, // R1 R2 R4
        '{5'b11010, 16'h0030, 4'd13, 32'h104, 8'd2, 32'h108, 1'b0, 8'h42, 32'hA000_0005}, // R2 pre up
        '{5'b00010, 16'h0003, 4'd13, 32'h100, 8'd2, 32'h0F8, 1'b0, 8'h40, 32'hA000_0001}, // R1 down
        '{5'b10011, 16'h0006, 4'd13, 32'h0FC, 8'd2, 32'h0F8, 1'b1, 8'd2,  32'hC000_003F}, // R2 pre down
        '{5'b01001, 16'h0101, 4'd13, 32'h100, 8'd2, 32'h100, 1'b1, 8'd8,  32'hC000_0041}, // R4 no wb
        '{5'b01011, 16'h0003, 4'd1,  32'h100, 8'd2, 32'hC000_0041, 1'b1, 8'd0, 32'hC000_0040} // R5
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        init_state();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_valid, "reset idle R12",
              {29'b0, busy, done, mem_valid}, 32'h0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            init_state();
            if (VECS[v].base != 4'd13) rf[VECS[v].base] = 32'h100;
            lat = v % 3;
            run(VECS[v].ctl, {12'h0, VECS[v].base, VECS[v].list});
            check(log_n == int'(VECS[v].exp_n), $sformatf("R3 vec%0d access count", v),
                  log_n, VECS[v].exp_n);
            check(first_addr == VECS[v].exp_first, $sformatf("R2 vec%0d first address", v),
                  first_addr, VECS[v].exp_first);
            check(rf[VECS[v].base] == VECS[v].exp_base, $sformatf("R4 R5 vec%0d base value", v),
                  rf[VECS[v].base], VECS[v].exp_base);
            if (VECS[v].chk_reg)
                check(rf[VECS[v].chk_idx[3:0]] == VECS[v].chk_val, $sformatf("R1 vec%0d reg data", v),
                      rf[VECS[v].chk_idx[3:0]], VECS[v].chk_val);
            else
                check(mem[VECS[v].chk_idx] == VECS[v].chk_val, $sformatf("R1 vec%0d mem data", v),
                      mem[VECS[v].chk_idx], VECS[v].chk_val);
        end

        // R6: stored r15 carries +8
        init_state(); lat = 1; rf[15] = 32'h2000;
        run(5'b01000, {12'h0, 4'd13, 16'h8000});
        check(mem[8'h40] == 32'h2008, "R6 stored pc offset", mem[8'h40], 32'h2008);

        // R7: loaded r15 aligned, no restore without user-bank bit
        init_state(); lat = 0; mem[8'h40] = 32'h1237;
        run(5'b01001, {12'h0, 4'd13, 16'h8000});
        check(rf[15] == 32'h1234, "R7 loaded pc aligned", rf[15], 32'h1234);
        check(restore_n == 0, "R7 no status restore", restore_n, 0);

        // R9: user-bank bit with r15 in list
        init_state(); lat = 2; mem[8'h41] = 32'h5557;
        run(5'b01101, {12'h0, 4'd13, 16'h8001});
        check(rf[0] == 32'hC000_0040, "R9 normal bank load", rf[0], 32'hC000_0040);
        check(rf[15] == 32'h5554, "R9 pc aligned", rf[15], 32'h5554);
        check(restore_n == 1, "R9 status restore once", restore_n, 1);
        check(usr[0] == 32'hB000_0000, "R9 user bank untouched", usr[0], 32'hB000_0000);

        // R8: user-bank bit without r15
        init_state(); lat = 1;
        run(5'b01101, {12'h0, 4'd13, 16'h0006});
        check(usr[1] == 32'hC000_0040, "R8 user r1 loaded", usr[1], 32'hC000_0040);
        check(usr[2] == 32'hC000_0041, "R8 user r2 loaded", usr[2], 32'hC000_0041);
        check(rf[1] == 32'hA000_0001, "R8 normal r1 untouched", rf[1], 32'hA000_0001);
        check(restore_n == 0, "R8 no status restore", restore_n, 0);

        // R10: store with user-bank bit, r15 included
        init_state(); lat = 0;
        run(5'b01100, {12'h0, 4'd13, 16'h8001});
        check(mem[8'h40] == 32'hB000_0000, "R10 user r0 stored", mem[8'h40], 32'hB000_0000);
        check(mem[8'h41] == 32'hB000_0017, "R10 user r15 stored +8", mem[8'h41], 32'hB000_0017);

        // R11: empty list
        init_state(); lat = 0;
        run(5'b01010, {12'h0, 4'd13, 16'h0000});
        check(log_n == 0, "R11 no bus cycles", log_n, 0);
        check(rf[13] == 32'h100, "R11 base unchanged", rf[13], 32'h100);

        // R12: start while busy is ignored
        init_state(); lat = 3;
        launch(5'b01001, {12'h0, 4'd13, 16'h00F0});
        repeat (3) @(negedge clk);
        {pre_index, up_dir, user_bank, write_back, load} = 5'b01010;
        opcode = {12'h0, 4'd13, 16'h0001};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_wait();
        repeat (10) @(negedge clk);
        check(log_n == 4, "R12 busy start ignored count", log_n, 4);
        check(rf[4] == 32'hC000_0040, "R12 first op completed", rf[4], 32'hC000_0040);
        check(rf[13] == 32'h100, "R12 no extra writeback", rf[13], 32'h100);
        check(mem[8'h40] == 32'hC000_0040, "R12 no extra store", mem[8'h40], 32'hC000_0040);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule